// File: doc/BRIEF.md
# Delta Sample Memory Reader

This block plays back 1-bit delta-coded audio held in main memory. Software programs a start page, a length, a control byte (rate, loop and interrupt enable) and an optional direct output level, then enables playback through a single enable bit. The reader then asks the memory system for one byte at a time, parks each returned byte in a one-byte buffer, and hands the buffer to an 8-bit shift register. At every expiry of a rate timer one bit leaves the shift register and nudges a 7-bit output level up or down by two.

The fetch interface is a valid/ready-style stream with back-pressure from the memory side: `req_valid` rises only while the buffer is empty and bytes remain, and then `req_valid` and `req_addr` stay steady for as long as the memory side needs. A byte is accepted in the cycle where `rsp_valid` is high while `req_valid` is high; `rsp_valid` outside a request is ignored. The reader drops the request in the cycle after acceptance. When the sample ends, the reader either starts the sample again (loop mode) or raises an interrupt if enabled. The arbitration that services the fetch and the mixing of the output level lie outside this block.

Top module: `delta_reader`

## Requirements
- R1: After reset `req_valid` is 0, `irq` is 0 and `level_out` is 0.
- R2: A playback fetches first from address 0xC000 + 64*start value and, without loop mode, fetches exactly 16*length value + 1 bytes, then raises no further requests.
- R3: After each accepted byte the fetch address rises by one, and 0xFFFF is followed by 0x8000.
- R4: A request is raised only while the sample buffer is empty; its address holds steady until a byte is accepted, and the request is low in the cycle after acceptance.
- R5: With loop mode (control bit 6) set, the byte that exhausts the count reloads the address to the start address and the count to the full length, sets no interrupt, and the next fetch waits for the buffer to empty.
- R6: With loop mode clear and interrupt enable (control bit 7) set, accepting the last byte sets `irq`.
- R7: `irq` is cleared by a control write with bit 7 clear and by any write to the enable bit.
- R8: Writing the enable bit as 0 zeroes the remaining count, resets the rate timer and drops any request; no request follows until playback is enabled again.
- R9: Writing the enable bit as 1 while the count is zero restarts from the start address with the full length; writing it as 1 while bytes remain leaves the address sequence untouched.
- R10: A direct-level write sets `level_out` to the low 7 bits of the written byte in the next cycle.
- R11: Each rate timer expiry (period (control bits 3:0 + 1) * RATE_STEP cycles) takes the shift register's least significant bit when not silent: a 1 adds 2 unless the result would exceed 127, a 0 subtracts 2 unless the result would go below 0.
- R12: Every 8 expiries the buffer moves into the shift register and playback is no longer silent; with an empty buffer the unit turns silent and the level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control byte: bit 7 irq enable, bit 6 loop, bits 3:0 rate index |
| level_we | input | 1 | Direct level write strobe |
| level_data | input | 8 | Direct level byte (low 7 bits used) |
| start_we | input | 1 | Start page write strobe |
| start_data | input | 8 | Start page value |
| len_we | input | 1 | Length write strobe |
| len_data | input | 8 | Length value |
| en_we | input | 1 | Enable bit write strobe |
| en_val | input | 1 | Enable bit value |
| req_valid | output | 1 | Fetch request pending |
| req_addr | output | 16 | Fetch address |
| rsp_valid | input | 1 | Fetched byte present (accepts the request) |
| rsp_byte | input | 8 | Fetched byte |
| level_out | output | 7 | Output level |
| irq | output | 1 | End-of-sample interrupt |

## Verification
The bench builds the reader with RATE_STEP = 1, so rate index 0 shifts one bit per clock and a byte drains in eight cycles; this keeps a 65-byte sample that crosses the 0xFFFF-to-0x8000 wrap and a looping sample run past its reload well inside the cycle budget. Rate index 15 then stretches each byte to 128 cycles, which opens a long window where the buffer is full and the shift register busy, so the rule that no request is raised while the buffer holds a byte becomes visible at the ports.

// File: rtl/delta_pkg.sv
package delta_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;

  localparam logic [ADDR_W-1:0] BASE_ADDR = 16'hC000;
  localparam logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000;

  function automatic logic [ADDR_W-1:0] first_addr(input logic [7:0] page);
    return BASE_ADDR + {2'b00, page, 6'b000000};
  endfunction

  function automatic logic [CNT_W-1:0] byte_total(input logic [7:0] len);
    return {len, 4'b0000} + 12'd1;
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == 16'hFFFF) ? WRAP_ADDR : a + 16'd1;
  endfunction
endpackage

// File: rtl/delta_fetch.sv
module delta_fetch
  import delta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic [7:0]        start_page,
  input  logic [7:0]        len_val,
  input  logic              en_we,
  input  logic              en_val,
  input  logic              buf_take,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              buf_valid,
  output logic [7:0]        buf_byte,
  output logic              irq,
  output logic              restart
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic              req_q, bvalid_q, irq_q;
  logic [7:0]        bbyte_q;
  logic              accept, stop, last_byte;

  assign accept    = req_q && rsp_valid;
  assign stop      = en_we && !en_val;
  assign restart   = en_we && en_val && (remain_q == '0);
  assign last_byte = (remain_q == 12'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= BASE_ADDR;
      remain_q <= '0;
      req_q    <= 1'b0;
      bvalid_q <= 1'b0;
      bbyte_q  <= 8'h00;
      irq_q    <= 1'b0;
    end else begin
      if (accept) begin
        bbyte_q  <= rsp_byte;
        bvalid_q <= 1'b1;
      end else if (buf_take) begin
        bvalid_q <= 1'b0;
      end

      if (stop || accept)
        req_q <= 1'b0;
      else if (!bvalid_q && remain_q != '0)
        req_q <= 1'b1;

      if (stop) begin
        remain_q <= '0;
      end else if (restart) begin
        remain_q <= byte_total(len_val);
        addr_q   <= first_addr(start_page);
      end else if (accept) begin
        if (last_byte && loop_en) begin
          remain_q <= byte_total(len_val);
          addr_q   <= first_addr(start_page);
        end else begin
          addr_q   <= step_addr(addr_q);
          remain_q <= remain_q - 12'd1;
        end
      end

      if (en_we || irq_clr)
        irq_q <= 1'b0;
      else if (accept && last_byte && !loop_en && irq_en)
        irq_q <= 1'b1;
    end
  end

  assign req_valid = req_q;
  assign req_addr  = addr_q;
  assign buf_valid = bvalid_q;
  assign buf_byte  = bbyte_q;
  assign irq       = irq_q;
endmodule

// File: rtl/delta_output.sv
module delta_output #(
  parameter int RATE_STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_idx,
  input  logic       restart,
  input  logic       stop,
  input  logic       buf_valid,
  input  logic [7:0] buf_byte,
  input  logic       level_we,
  input  logic [6:0] level_val,
  output logic       buf_take,
  output logic [6:0] level
);
  localparam int RATE_W = $clog2(16 * RATE_STEP + 1);

  logic [RATE_W-1:0] cnt_q, period_m1;
  logic [7:0]        shift_q;
  logic [3:0]        bits_q;
  logic              silent_q;
  logic [6:0]        level_q;
  logic              tick;

  assign period_m1 = RATE_W'((int'(rate_idx) + 1) * RATE_STEP - 1);
  assign tick      = (cnt_q == '0);
  assign buf_take  = tick && (bits_q == 4'd1) && buf_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shift_q  <= 8'h00;
      bits_q   <= 4'd8;
      silent_q <= 1'b1;
      level_q  <= 7'd0;
    end else begin
      if (restart)
        cnt_q <= period_m1;
      else if (stop)
        cnt_q <= '0;
      else if (tick)
        cnt_q <= period_m1;
      else
        cnt_q <= cnt_q - 1'b1;

      if (level_we) begin
        level_q <= level_val;
      end else if (tick && !silent_q) begin
        if (shift_q[0]) begin
          if (level_q <= 7'd125) level_q <= level_q + 7'd2;
        end else begin
          if (level_q >= 7'd2) level_q <= level_q - 7'd2;
        end
      end

      if (tick) begin
        if (!silent_q) shift_q <= {1'b0, shift_q[7:1]};
        if (bits_q == 4'd1) begin
          bits_q <= 4'd8;
          if (buf_valid) begin
            shift_q  <= buf_byte;
            silent_q <= 1'b0;
          end else begin
            silent_q <= 1'b1;
          end
        end else begin
          bits_q <= bits_q - 4'd1;
        end
      end
    end
  end

  assign level = level_q;
endmodule

// File: rtl/delta_reader.sv
module delta_reader
  import delta_pkg::*;
#(
  parameter int RATE_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_data,
  input  logic        level_we,
  input  logic [7:0]  level_data,
  input  logic        start_we,
  input  logic [7:0]  start_data,
  input  logic        len_we,
  input  logic [7:0]  len_data,
  input  logic        en_we,
  input  logic        en_val,
  output logic        req_valid,
  output logic [15:0] req_addr,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_byte,
  output logic [6:0]  level_out,
  output logic        irq
);
  logic       irq_en_q, loop_q;
  logic [3:0] rate_q;
  logic [7:0] start_q, len_q;
  logic       buf_valid, buf_take, restart;
  logic [7:0] buf_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      loop_q   <= 1'b0;
      rate_q   <= 4'd0;
      start_q  <= 8'h00;
      len_q    <= 8'h00;
    end else begin
      if (ctrl_we) begin
        irq_en_q <= ctrl_data[7];
        loop_q   <= ctrl_data[6];
        rate_q   <= ctrl_data[3:0];
      end
      if (start_we) start_q <= start_data;
      if (len_we)   len_q   <= len_data;
    end
  end

  delta_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_en    (loop_q),
    .irq_en     (irq_en_q),
    .irq_clr    (ctrl_we && !ctrl_data[7]),
    .start_page (start_q),
    .len_val    (len_q),
    .en_we      (en_we),
    .en_val     (en_val),
    .buf_take   (buf_take),
    .rsp_valid  (rsp_valid),
    .rsp_byte   (rsp_byte),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .buf_valid  (buf_valid),
    .buf_byte   (buf_byte),
    .irq        (irq),
    .restart    (restart)
  );

  delta_output #(.RATE_STEP(RATE_STEP)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_idx  (rate_q),
    .restart   (restart),
    .stop      (en_we && !en_val),
    .buf_valid (buf_valid),
    .buf_byte  (buf_byte),
    .level_we  (level_we),
    .level_val (level_data[6:0]),
    .buf_take  (buf_take),
    .level     (level_out)
  );
endmodule

// File: rtl/delta_reader_chk.sv
module delta_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_we,
  input logic [7:0]  ctrl_data,
  input logic        level_we,
  input logic [7:0]  level_data,
  input logic        en_we,
  input logic        en_val,
  input logic        req_valid,
  input logic [15:0] req_addr,
  input logic        rsp_valid,
  input logic [6:0]  level_out,
  input logic        irq
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid && !(en_we && !en_val) |=> req_valid && $stable(req_addr));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_valid |=> !req_valid);

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[15]);

  // R8
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !en_val |=> !req_valid);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we || (ctrl_we && !ctrl_data[7]) |=> !irq);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(req_valid && rsp_valid));

  // R10
  level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_we |=> level_out == $past(level_data[6:0]));
endmodule

bind delta_reader delta_reader_chk u_chk (.*);

// File: tb/tb_delta_reader.sv
`timescale 1ns/1ps
module tb_delta_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 0, level_we = 0, start_we = 0, len_we = 0, en_we = 0, en_val = 0;
  logic [7:0]  ctrl_data = 0, level_data = 0, start_data = 0, len_data = 0;
  logic        rsp_valid = 0;
  logic [7:0]  rsp_byte = 0;
  logic        req_valid, irq;
  logic [15:0] req_addr;
  logic [6:0]  level_out;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  delta_reader #(.RATE_STEP(1)) dut (.*);

  typedef struct packed {
    logic [7:0] st; logic [7:0] ln; logic lp; logic ie; logic [7:0] n; logic xirq;
  } vec_t;
  localparam vec_t VECS [0:4] = '{
    '{8'h00, 8'h00, 1'b0, 1'b1, 8'd1,  1'b1},
    '{8'h01, 8'h01, 1'b0, 1'b0, 8'd17, 1'b0},
    '{8'hFF, 8'h04, 1'b0, 1'b1, 8'd65, 1'b1},
    '{8'h02, 8'h00, 1'b1, 1'b1, 8'd3,  1'b0},
    '{8'hFF, 8'h03, 1'b1, 1'b0, 8'd60, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_data = d; ctrl_we = 1; @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_level(input logic [7:0] d);
    level_data = d; level_we = 1; @(negedge clk); level_we = 0;
  endtask
  task automatic wr_start(input logic [7:0] d);
    start_data = d; start_we = 1; @(negedge clk); start_we = 0;
  endtask
  task automatic wr_len(input logic [7:0] d);
    len_data = d; len_we = 1; @(negedge clk); len_we = 0;
  endtask
  task automatic wr_en(input logic v);
    en_val = v; en_we = 1; @(negedge clk); en_we = 0;
  endtask

  // wait for a request, compare its address, deliver a byte
  task automatic serve(input logic [15:0] exp, input logic [7:0] data, input string req);
    int w = 0;
    while (!req_valid && w < 3000) begin @(negedge clk); w++; end
    check(req_valid, req, {31'd0, req_valid}, 32'd1);
    check(req_addr == exp, req, {16'd0, req_addr}, {16'd0, exp});
    rsp_byte = data; rsp_valid = 1;
    @(negedge clk);
    rsp_valid = 0;
    check(!req_valid, "R4 request low after accept", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic quiet(input string req, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (req_valid) seen = 1; end
    check(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [15:0] a, s;
    int rem, tot, gap;
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 reset state
    check(!req_valid, "R1 req", {31'd0, req_valid}, 0);
    check(!irq, "R1 irq", {31'd0, irq}, 0);
    check(level_out == 0, "R1 level", {25'd0, level_out}, 0);

    // table of sample runs: R2, R3, R5, R6
    for (int v = 0; v < 5; v++) begin
      wr_en(0);
      tick(60);
      wr_ctrl({VECS[v].ie, VECS[v].lp, 6'd0});
      wr_start(VECS[v].st);
      wr_len(VECS[v].ln);
      wr_en(1);
      s = 16'hC000 + {2'b00, VECS[v].st, 6'd0};
      tot = int'(VECS[v].ln) * 16 + 1;
      a = s; rem = tot;
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        serve(a, 8'hA5, VECS[v].lp ? "R5 loop address" : (a == 16'h8000 ? "R3 wrap address" : "R2 address"));
        a = (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
        rem--;
        if (rem == 0 && VECS[v].lp) begin a = s; rem = tot; end
      end
      tick(40);
      check(irq == VECS[v].xirq, VECS[v].lp ? "R5 no irq in loop" : "R6 irq at end", {31'd0, irq}, {31'd0, VECS[v].xirq});
      if (!VECS[v].lp) quiet("R2 no fetch past length", 60);
    end

    // R7: control write with bit 7 clear drops irq
    wr_en(0); tick(60);
    wr_ctrl(8'h80); wr_start(8'h00); wr_len(8'h00); wr_en(1);
    serve(16'hC000, 8'h00, "R6 address");
    tick(2);
    check(irq, "R6 irq set", {31'd0, irq}, 1);
    wr_ctrl(8'h00);
    check(!irq, "R7 ctrl clears irq", {31'd0, irq}, 0);
    wr_ctrl(8'h80); wr_en(1);
    serve(16'hC000, 8'h00, "R9 restart address");
    tick(2);
    check(irq, "R6 irq set again", {31'd0, irq}, 1);
    wr_en(0);
    check(!irq, "R7 enable write clears irq", {31'd0, irq}, 0);

    // R9: enable while bytes remain keeps sequence; R8: disable stops
    tick(60);
    wr_ctrl(8'h00); wr_start(8'h00); wr_len(8'h01); wr_en(1);
    serve(16'hC000, 8'h00, "R9 address");
    serve(16'hC001, 8'h00, "R9 address");
    serve(16'hC002, 8'h00, "R9 address");
    wr_en(1);
    serve(16'hC003, 8'h00, "R9 no restart while bytes remain");
    wr_en(0);
    check(!req_valid, "R8 request dropped", {31'd0, req_valid}, 0);
    quiet("R8 no fetch after disable", 200);
    wr_en(1);
    serve(16'hC000, 8'h00, "R9 restart after disable");

    // R4: with a full buffer and busy shifter no request for a long window
    wr_en(0); tick(60);
    wr_ctrl(8'h0F); wr_en(1);
    serve(16'hC000, 8'h00, "R4 address");
    serve(16'hC001, 8'h00, "R4 address");
    gap = 0;
    while (!req_valid && gap < 400) begin @(negedge clk); gap++; end
    check(gap >= 100 && gap < 400, "R4 waits for empty buffer", gap, 100);
    wr_en(0); tick(300);
    wr_ctrl(8'h00);

    // R10 direct level
    wr_level(8'hFF);
    check(level_out == 7'd127, "R10 level low 7 bits", {25'd0, level_out}, 127);
    wr_level(8'h85);
    check(level_out == 7'd5, "R10 level top bit dropped", {25'd0, level_out}, 5);

    // R11 saturation high, R12 silence holds
    wr_level(8'd120); wr_len(8'h00); wr_en(1);
    serve(16'hC000, 8'hFF, "R11 address");
    tick(200);
    check(level_out == 7'd126, "R11 upper clamp", {25'd0, level_out}, 126);
    wr_en(0); tick(60);
    wr_level(8'd3); wr_en(1);
    serve(16'hC000, 8'h00, "R11 address");
    tick(200);
    check(level_out == 7'd1, "R11 lower clamp", {25'd0, level_out}, 1);
    wr_en(0); tick(60);
    wr_level(8'd64); wr_en(1);
    serve(16'hC000, 8'h0F, "R11 address");
    tick(12);
    wr_en(0);
    tick(200);
    check(level_out == 7'd64, "R12 level holds when silent", {25'd0, level_out}, 64);

    finish_run();
  end
endmodule